// File: doc/BRIEF.md
# Switch/LED PCI Bus Target

This block is a 32-bit PCI bus target for a 33 MHz bus. It watches the multiplexed address/data lines for an address phase, decodes the bus command and claims the cycle if it falls in its I/O window, its memory window or its own configuration header. A claimed cycle is completed without wait states. Each DWORD that is written to the I/O or memory window puts its lowest byte onto an 8-bit LED register. Each DWORD that is read from either window returns the 8 switch inputs, zero-extended. The bus pins are split into input, output and output-enable signals, so the pad ring supplies the tri-state and open-drain drivers.

The configuration header holds identification words, a command register, one I/O base register, one memory base register and an interrupt line byte. Both windows stay closed until software programs a base register and sets the matching enable bit. The block drives parity on reads, checks parity on writes and reports a bad write through PERR. An interrupt request asks for the open-drain line to be pulled low. The line is never driven high.

The bus sets the pace, so the backend has no valid/ready handshake. A data phase completes on every edge where the initiator holds IRDY low. The block cannot apply back-pressure, because TRDY is never withdrawn during a transfer. The LED register simply holds its last value. Reads sample the switches when the data phase begins.

Top module: `pci_io_target`

## Requirements
- R1: Decode follows C/BE[3:0] in the address phase. I/O read/write (0010/0011) is claimed only when command bit 0 is set and the address matches the I/O base register above its 16-byte window. Memory read/write (0110/0111) is claimed only when command bit 1 is set and the address matches the memory base register above its 4 KiB window. Configuration read/write (1010/1011) is claimed only when IDSEL is high and AD[1:0] is 00. Any other cycle leaves DEVSEL, TRDY and AD undriven.
- R2: DEVSEL and TRDY are undriven in the cycle after the edge that samples the address phase. Both go low together after the next edge (medium decode timing).
- R3: TRDY stays low while DEVSEL is low. One DWORD is transferred on each edge where IRDY is low, and the phase that completes with FRAME high is the last one. After that edge AD is released, and DEVSEL and TRDY are driven high for one cycle. They are then released.
- R4: An I/O or memory write phase with byte enable 0 active (C/BE[0] low) loads AD[7:0] into the LED output at its completing edge. A write with C/BE[0] high, a configuration write or an unclaimed write leaves the LED output unchanged. The LED output resets to 0.
- R5: An I/O or memory read phase presents {24'b0, switches} on AD. The switches are sampled at the edge that starts that phase.
- R6: Configuration reads by dword index (AD[7:2]) return the following values: index 0 is {device ID, vendor ID}; index 1 is {16'h0200, 8'h00, command}; index 2 is the class/revision word; index 4 is the I/O base register; index 5 is the memory base register; index 15 is {16'h0000, 8'h01, interrupt line}. Every other index reads 0.
- R7: Configuration writes honour the byte enables. Only command bits 0 (I/O enable), 1 (memory enable) and 6 (parity response) are writable. After all ones are written, the I/O base register reads FFFF_FFF1 and the memory base register reads FFFF_F000.
- R8: PAR is driven in the cycle after each cycle in which the block drives AD. It is even parity over that cycle's AD[31:0] and C/BE[3:0].
- R9: The initiator drives PAR in the cycle after a write data phase. If that PAR mismatches, PERR is low in the second cycle after the phase, but only when command bit 6 is set. After a low PERR, the pin is driven high for one cycle before it is released.
- R10: The interrupt pull-down enable follows the interrupt request one clock edge later. The block has no way to drive the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus as seen on the pins |
| ad_o | output | 32 | Read data to drive onto the bus |
| ad_oe | output | 1 | Output enable for ad_o |
| cbe_i | input | 4 | Command / active-low byte enables |
| par_i | input | 1 | Parity from the initiator |
| par_o | output | 1 | Parity for read data |
| par_oe | output | 1 | Output enable for par_o |
| frame_n_i | input | 1 | FRAME, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| idsel_i | input | 1 | Configuration select |
| devsel_n_o | output | 1 | Device select, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| ctl_oe | output | 1 | Shared output enable for DEVSEL and TRDY |
| perr_n_o | output | 1 | Data parity error, active low |
| perr_oe | output | 1 | Output enable for perr_n_o |
| irq_i | input | 1 | Interrupt request from the backend |
| inta_oe | output | 1 | Pull the open-drain interrupt line low |
| sw_i | input | 8 | Switch inputs |
| led_o | output | 8 | LED register |

## Verification
The bench counts edges from the edge that samples the address phase. DEVSEL and TRDY are due after the second edge, never after the first. LED values are due right after the completing edge of a data phase. PAR is due one cycle after the AD value it covers. PERR is due after the edge that follows the phase's completing edge, so it appears in the second cycle after the phase, and the interrupt enable is due one edge after the request. Each check waits exactly that many clock edges. Outputs are sampled on the falling edge, with inputs changed only at that point, so every expected value is read in the one cycle the requirement names.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_XFER,
    ST_TURN,
    ST_BUSY
  } tgt_state_e;

  typedef enum logic [1:0] {
    SP_NONE,
    SP_IO,
    SP_MEM,
    SP_CFG
  } space_e;

  // upper three command bits select the space; bit 0 marks a write
  localparam logic [2:0] CMDG_IO  = 3'b001;
  localparam logic [2:0] CMDG_MEM = 3'b011;
  localparam logic [2:0] CMDG_CFG = 3'b101;

  localparam logic [5:0] IDX_ID    = 6'd0;
  localparam logic [5:0] IDX_CMD   = 6'd1;
  localparam logic [5:0] IDX_CLASS = 6'd2;
  localparam logic [5:0] IDX_BIO   = 6'd4;
  localparam logic [5:0] IDX_BMEM  = 6'd5;
  localparam logic [5:0] IDX_INT   = 6'd15;

  localparam logic [7:0] CMD_WMASK = 8'h43;

  function automatic logic [31:0] win_mask(input int unsigned bits);
    return ~((32'd1 << bits) - 32'd1);
  endfunction

endpackage

// File: rtl/pci_tgt_cfg.sv
module pci_tgt_cfg
  import pci_tgt_pkg::*;
#(
  parameter logic [15:0] VEN_ID    = 16'h1AB5,
  parameter logic [15:0] DEV_ID    = 16'h0C21,
  parameter logic [31:0] CLASS_REV = 32'hFF00_0001,
  parameter int unsigned IO_BITS   = 4,
  parameter int unsigned MEM_BITS  = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  idx,
  input  logic [31:0] wdata,
  input  logic [3:0]  be_n,
  output logic [31:0] rdata,
  output logic        io_en,
  output logic        mem_en,
  output logic        perr_en,
  output logic [31:0] bar_io,
  output logic [31:0] bar_mem
);

  localparam logic [31:0] IO_WIN  = win_mask(IO_BITS);
  localparam logic [31:0] MEM_WIN = win_mask(MEM_BITS);
  localparam int unsigned LANES   = 4;

  logic [7:0]  cmd_q;
  logic [7:0]  int_line_q;
  logic [31:0] bio_q;
  logic [31:0] bmem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      int_line_q <= '0;
      bio_q      <= '0;
      bmem_q     <= '0;
    end else if (wr_en) begin
      if (idx == IDX_CMD && !be_n[0]) cmd_q <= wdata[7:0] & CMD_WMASK;
      if (idx == IDX_INT && !be_n[0]) int_line_q <= wdata[7:0];
      for (int b = 0; b < LANES; b++) begin
        if (!be_n[b]) begin
          if (idx == IDX_BIO)  bio_q[8*b +: 8]  <= wdata[8*b +: 8];
          if (idx == IDX_BMEM) bmem_q[8*b +: 8] <= wdata[8*b +: 8];
        end
      end
    end
  end

  assign bar_io  = (bio_q & IO_WIN) | 32'd1;
  assign bar_mem = bmem_q & MEM_WIN;
  assign io_en   = cmd_q[0];
  assign mem_en  = cmd_q[1];
  assign perr_en = cmd_q[6];

  always_comb begin
    case (idx)
      IDX_ID:    rdata = {DEV_ID, VEN_ID};
      IDX_CMD:   rdata = {16'h0200, 8'h00, cmd_q};
      IDX_CLASS: rdata = CLASS_REV;
      IDX_BIO:   rdata = bar_io;
      IDX_BMEM:  rdata = bar_mem;
      IDX_INT:   rdata = {16'h0000, 8'h01, int_line_q};
      default:   rdata = '0;
    endcase
  end

  // R7: only the three defined command bits can ever become set
  p_cmd_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q & ~CMD_WMASK) == 8'h00)
    else $error("command register holds an undefined bit");

endmodule

// File: rtl/pci_tgt_par.sv
module pci_tgt_par (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_o,
  input  logic        ad_oe,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_i,
  input  logic        par_i,
  input  logic        wr_done,
  input  logic        perr_en,
  output logic        par_o,
  output logic        par_oe,
  output logic        perr_n_o,
  output logic        perr_oe
);

  logic chk_v;
  logic exp_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_o    <= 1'b0;
      par_oe   <= 1'b0;
      chk_v    <= 1'b0;
      exp_par  <= 1'b0;
      perr_n_o <= 1'b1;
      perr_oe  <= 1'b0;
    end else begin
      par_o    <= ^{ad_o, cbe_i};
      par_oe   <= ad_oe;
      chk_v    <= wr_done;
      exp_par  <= ^{ad_i, cbe_i};
      perr_n_o <= !(chk_v && (par_i != exp_par) && perr_en);
      perr_oe  <= chk_v | (perr_oe & ~perr_n_o);
    end
  end

  // R9: an error report needs parity response enabled when it was judged
  p_perr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_o) |-> $past(perr_en))
    else $error("PERR reported with parity response off");

  // R9: a low PERR is followed by a driven cycle, never a float
  p_perr_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_o) |=> perr_oe)
    else $error("PERR floated straight from low");

endmodule

// File: rtl/pci_io_target.sv
module pci_io_target
  import pci_tgt_pkg::*;
#(
  parameter logic [15:0] VEN_ID    = 16'h1AB5,
  parameter logic [15:0] DEV_ID    = 16'h0C21,
  parameter logic [31:0] CLASS_REV = 32'hFF00_0001,
  parameter int unsigned IO_BITS   = 4,
  parameter int unsigned MEM_BITS  = 12,
  parameter int unsigned SW_W      = 8,
  parameter int unsigned LED_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ad_i,
  output logic [31:0]      ad_o,
  output logic             ad_oe,
  input  logic [3:0]       cbe_i,
  input  logic             par_i,
  output logic             par_o,
  output logic             par_oe,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             idsel_i,
  output logic             devsel_n_o,
  output logic             trdy_n_o,
  output logic             ctl_oe,
  output logic             perr_n_o,
  output logic             perr_oe,
  input  logic             irq_i,
  output logic             inta_oe,
  input  logic [SW_W-1:0]  sw_i,
  output logic [LED_W-1:0] led_o
);

  localparam logic [31:0] IO_WIN  = win_mask(IO_BITS);
  localparam logic [31:0] MEM_WIN = win_mask(MEM_BITS);

  tgt_state_e  st_q;
  space_e      sp_q, dec_sp, cur_sp;
  logic [31:0] addr_q;
  logic [3:0]  cmd_q;
  logic        idsel_q;
  logic        is_wr, xfer, cfg_wr, wr_done;
  logic [31:0] cfg_rdata, bar_io, bar_mem, rd_word;
  logic        io_en, mem_en, perr_en;

  assign is_wr   = cmd_q[0];
  assign xfer    = (st_q == ST_XFER) && !irdy_n_i;
  assign wr_done = xfer && is_wr;
  assign cfg_wr  = wr_done && (sp_q == SP_CFG);

  always_comb begin
    dec_sp = SP_NONE;
    case (cmd_q[3:1])
      CMDG_IO:  if (io_en && (((addr_q ^ bar_io) & IO_WIN) == '0)) dec_sp = SP_IO;
      CMDG_MEM: if (mem_en && (((addr_q ^ bar_mem) & MEM_WIN) == '0)) dec_sp = SP_MEM;
      CMDG_CFG: if (idsel_q && addr_q[1:0] == 2'b00) dec_sp = SP_CFG;
      default:  dec_sp = SP_NONE;
    endcase
  end

  assign cur_sp  = (st_q == ST_DECODE) ? dec_sp : sp_q;
  assign rd_word = (cur_sp == SP_CFG) ? cfg_rdata
                                      : {{(32-SW_W){1'b0}}, sw_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sp_q       <= SP_NONE;
      addr_q     <= '0;
      cmd_q      <= '0;
      idsel_q    <= 1'b0;
      devsel_n_o <= 1'b1;
      trdy_n_o   <= 1'b1;
      ctl_oe     <= 1'b0;
      ad_o       <= '0;
      ad_oe      <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (!frame_n_i) begin
          addr_q  <= ad_i;
          cmd_q   <= cbe_i;
          idsel_q <= idsel_i;
          st_q    <= ST_DECODE;
        end
        ST_DECODE: if (dec_sp != SP_NONE) begin
          sp_q       <= dec_sp;
          devsel_n_o <= 1'b0;
          trdy_n_o   <= 1'b0;
          ctl_oe     <= 1'b1;
          if (!is_wr) begin
            ad_oe <= 1'b1;
            ad_o  <= rd_word;
          end
          st_q <= ST_XFER;
        end else begin
          st_q <= ST_BUSY;
        end
        ST_XFER: if (!irdy_n_i) begin
          if (frame_n_i) begin
            devsel_n_o <= 1'b1;
            trdy_n_o   <= 1'b1;
            ad_oe      <= 1'b0;
            st_q       <= ST_TURN;
          end else if (!is_wr) begin
            ad_o <= rd_word;
          end
        end
        ST_TURN: begin
          ctl_oe <= 1'b0;
          st_q   <= ST_IDLE;
        end
        ST_BUSY: if (frame_n_i && irdy_n_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_o   <= '0;
      inta_oe <= 1'b0;
    end else begin
      inta_oe <= irq_i;
      if (wr_done && sp_q != SP_CFG && !cbe_i[0]) led_o <= ad_i[LED_W-1:0];
    end
  end

  pci_tgt_cfg #(
    .VEN_ID(VEN_ID), .DEV_ID(DEV_ID), .CLASS_REV(CLASS_REV),
    .IO_BITS(IO_BITS), .MEM_BITS(MEM_BITS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .idx(addr_q[7:2]),
    .wdata(ad_i), .be_n(cbe_i), .rdata(cfg_rdata),
    .io_en(io_en), .mem_en(mem_en), .perr_en(perr_en),
    .bar_io(bar_io), .bar_mem(bar_mem)
  );

  pci_tgt_par u_par (
    .clk(clk), .rst_n(rst_n), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .cbe_i(cbe_i), .par_i(par_i), .wr_done(wr_done), .perr_en(perr_en),
    .par_o(par_o), .par_oe(par_oe), .perr_n_o(perr_n_o), .perr_oe(perr_oe)
  );

  // R3: zero wait states, TRDY moves together with DEVSEL
  p_trdy_with_devsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> (devsel_n_o == trdy_n_o))
    else $error("TRDY differs from DEVSEL");

  // R3: AD is driven only inside a claimed cycle
  p_ad_claimed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (ctl_oe && !devsel_n_o))
    else $error("AD driven outside a claimed cycle");

  // R3: a driven-high DEVSEL lasts one cycle before release
  p_ctl_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && devsel_n_o) |=> !ctl_oe)
    else $error("DEVSEL/TRDY not released after turnaround");

  // R1: no configuration claim without IDSEL
  p_cfg_needs_idsel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DECODE && cmd_q[3:1] == CMDG_CFG && !idsel_q) |=> !ctl_oe)
    else $error("configuration cycle claimed without IDSEL");

  // R4: LED changes only on a completed data phase
  p_led_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(led_o))
    else $error("LED changed outside a data phase");

endmodule

// File: tb/tb_pci_io_target.sv
module tb_pci_io_target;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        par_i = 1'b0;
  logic        frame_n_i = 1'b1;
  logic        irdy_n_i = 1'b1;
  logic        idsel_i = 1'b0;
  logic        irq_i = 1'b0;
  logic [7:0]  sw_i = '0;
  logic [31:0] ad_o;
  logic        ad_oe, par_o, par_oe, devsel_n_o, trdy_n_o, ctl_oe;
  logic        perr_n_o, perr_oe, inta_oe;
  logic [7:0]  led_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [7:0] m_led = 8'h00;
  bit m_perr_en = 1'b0;

  always #2.5 clk = ~clk;

  pci_io_target dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .cbe_i(cbe_i), .par_i(par_i), .par_o(par_o), .par_oe(par_oe),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .idsel_i(idsel_i),
    .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o), .ctl_oe(ctl_oe),
    .perr_n_o(perr_n_o), .perr_oe(perr_oe), .irq_i(irq_i),
    .inta_oe(inta_oe), .sw_i(sw_i), .led_o(led_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      summary();
      $finish;
    end
  end

  function automatic logic epar(input logic [31:0] d, input logic [3:0] c);
    return ^{d, c};
  endfunction

  // one bus transaction; every check sits in the cycle the requirement names
  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr,
                     input logic idsel, input int nph, input logic [31:0] wbase,
                     input logic [3:0] be, input int badph, input logic claim,
                     input logic [31:0] rexp);
    bit wr = cmd[0];
    bit iomem = (cmd[3:1] != 3'b101);
    bit pen = m_perr_en;
    logic [31:0] rec_ad;
    logic [3:0]  rec_cbe;
    @(negedge clk);
    frame_n_i = 1'b0; irdy_n_i = 1'b1; ad_i = addr; cbe_i = cmd; idsel_i = idsel;
    @(negedge clk);
    chk("R2", "ctl_oe one edge after address", {31'b0, ctl_oe}, 32'd0);
    idsel_i = 1'b0; irdy_n_i = 1'b0; frame_n_i = (nph == 1);
    ad_i = wr ? wbase : 32'h0; cbe_i = be;
    @(negedge clk);
    if (claim) begin
      chk("R2", "devsel/trdy/oe after second edge",
          {29'b0, ctl_oe, devsel_n_o, trdy_n_o}, 32'b100);
    end else begin
      chk("R1", "unclaimed ctl_oe", {31'b0, ctl_oe}, 32'd0);
      chk("R1", "unclaimed ad_oe", {31'b0, ad_oe}, 32'd0);
    end
    for (int i = 0; i < nph; i++) begin
      if (!wr && claim) begin
        chk("R3", "ad_oe during read phase", {31'b0, ad_oe}, 32'd1);
        chk("R5", "read data", ad_o, rexp);
        rec_ad = ad_o;
        rec_cbe = cbe_i;
      end
      @(negedge clk);
      if (!wr && claim) begin
        chk("R8", "par_oe after read cycle", {31'b0, par_oe}, 32'd1);
        chk("R8", "read parity", {31'b0, par_o}, {31'b0, epar(rec_ad, rec_cbe)});
      end
      if (wr) begin
        if (claim && iomem && !be[0]) m_led = 8'(wbase + 32'(i));
        chk("R4", "led after write phase", {24'b0, led_o}, {24'b0, m_led});
      end
      par_i = wr ? (epar(wbase + 32'(i), be) ^ (badph == i)) : 1'b0;
      if (i > 0 && wr && claim) begin
        chk("R9", "perr for earlier phase", {31'b0, perr_oe && !perr_n_o},
            {31'b0, pen && (badph == i - 1)});
      end
      if (i < nph - 1) begin
        ad_i = wr ? wbase + 32'(i + 1) : 32'h0;
        frame_n_i = (i + 1 == nph - 1);
      end else begin
        frame_n_i = 1'b1; irdy_n_i = 1'b1; ad_i = '0; cbe_i = '0;
      end
    end
    if (claim) begin
      chk("R3", "turnaround drives high, AD off",
          {28'b0, ctl_oe, devsel_n_o, trdy_n_o, ad_oe}, 32'b1110);
    end
    @(negedge clk);
    par_i = 1'b0;
    chk("R3", "released after turnaround", {31'b0, ctl_oe}, 32'd0);
    if (wr && claim) begin
      chk("R9", "perr for last phase", {31'b0, perr_oe && !perr_n_o},
          {31'b0, pen && (badph == nph - 1)});
    end
    @(negedge clk);
    chk("R9", "perr not low when idle", {31'b0, perr_oe && !perr_n_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "reset oe flags", {27'b0, ctl_oe, ad_oe, par_oe, perr_oe, inta_oe}, 32'd0);
    chk("R4", "reset led", {24'b0, led_o}, 32'd0);

    // R1: configuration without IDSEL, misaligned, and I/O before enable
    txn(4'b1010, 32'h0000_0000, 1'b0, 1, 0, 4'h0, -1, 1'b0, 0);
    txn(4'b1010, 32'h0000_0001, 1'b1, 1, 0, 4'h0, -1, 1'b0, 0);
    txn(4'b0010, 32'h0000_0000, 1'b0, 1, 0, 4'h0, -1, 1'b0, 0);
    // R6: identification words
    txn(4'b1010, 32'h0000_0000, 1'b1, 1, 0, 4'h0, -1, 1'b1, 32'h0C21_1AB5);
    txn(4'b1010, 32'h0000_0008, 1'b1, 1, 0, 4'h0, -1, 1'b1, 32'hFF00_0001);
    txn(4'b1010, 32'h0000_000C, 1'b1, 1, 0, 4'h0, -1, 1'b1, 32'h0);
    // R7: sizing
    txn(4'b1011, 32'h0000_0010, 1'b1, 1, 32'hFFFF_FFFF, 4'h0, -1, 1'b1, 0);
    txn(4'b1010, 32'h0000_0010, 1'b1, 1, 0, 4'h0, -1, 1'b1, 32'hFFFF_FFF1);
    txn(4'b1011, 32'h0000_0014, 1'b1, 1, 32'hFFFF_FFFF, 4'h0, -1, 1'b1, 0);
    txn(4'b1010, 32'h0000_0014, 1'b1, 1, 0, 4'h0, -1, 1'b1, 32'hFFFF_F000);
    // R7: program bases, byte enables respected on the memory base
    txn(4'b1011, 32'h0000_0010, 1'b1, 1, 32'h0000_1000, 4'h0, -1, 1'b1, 0);
    txn(4'b1011, 32'h0000_0014, 1'b1, 1, 32'h8000_0000, 4'h0, -1, 1'b1, 0);
    txn(4'b1011, 32'h0000_0014, 1'b1, 1, 32'h1234_5678, 4'b0111, -1, 1'b1, 0);
    txn(4'b1010, 32'h0000_0014, 1'b1, 1, 0, 4'h0, -1, 1'b1, 32'h1200_0000);
    txn(4'b1011, 32'h0000_0014, 1'b1, 1, 32'h8000_0000, 4'h0, -1, 1'b1, 0);
    txn(4'b1011, 32'h0000_0004, 1'b1, 1, 32'hFFFF_FFFF, 4'h0, -1, 1'b1, 0);
    m_perr_en = 1'b1;
    txn(4'b1010, 32'h0000_0004, 1'b1, 1, 0, 4'h0, -1, 1'b1, 32'h0200_0043);
    txn(4'b1011, 32'h0000_003C, 1'b1, 1, 32'h0000_000B, 4'h0, -1, 1'b1, 0);
    txn(4'b1010, 32'h0000_003C, 1'b1, 1, 0, 4'h0, -1, 1'b1, 32'h0000_010B);
    txn(4'b1010, 32'h0000_0020, 1'b1, 1, 0, 4'h0, -1, 1'b1, 32'h0);

    // R4: I/O write, then a write with byte 0 disabled
    txn(4'b0011, 32'h0000_1004, 1'b0, 1, 32'h0000_00A5, 4'h0, -1, 1'b1, 0);
    txn(4'b0011, 32'h0000_1008, 1'b0, 1, 32'h0000_0077, 4'b0001, -1, 1'b1, 0);
    // R1: outside the I/O window
    txn(4'b0011, 32'h0000_2000, 1'b0, 1, 32'h0000_0033, 4'h0, -1, 1'b0, 0);
    // R1: other command code is ignored
    txn(4'b0001, 32'h0000_1000, 1'b0, 1, 32'h0000_0044, 4'h0, -1, 1'b0, 0);
    // R3 R4: memory burst
    txn(4'b0111, 32'h8000_0010, 1'b0, 3, 32'h1122_3340, 4'h0, -1, 1'b1, 0);
    // R5 R8: reads
    sw_i = 8'h5A;
    txn(4'b0110, 32'h8000_0100, 1'b0, 2, 0, 4'h0, -1, 1'b1, 32'h0000_005A);
    sw_i = 8'hC3;
    txn(4'b0010, 32'h0000_100C, 1'b0, 1, 0, 4'b1010, -1, 1'b1, 32'h0000_00C3);
    // R9: parity error on second phase, then with response disabled
    txn(4'b0111, 32'h8000_0020, 1'b0, 3, 32'h0000_0060, 4'h0, 1, 1'b1, 0);
    txn(4'b1011, 32'h0000_0004, 1'b1, 1, 32'h0000_0003, 4'h0, -1, 1'b1, 0);
    m_perr_en = 1'b0;
    txn(4'b0011, 32'h0000_1000, 1'b0, 1, 32'h0000_0019, 4'h0, 0, 1'b1, 0);
    // R1: memory disabled by clearing bit 1
    txn(4'b1011, 32'h0000_0004, 1'b1, 1, 32'h0000_0001, 4'h0, -1, 1'b1, 0);
    txn(4'b0111, 32'h8000_0000, 1'b0, 1, 32'h0000_00EE, 4'h0, -1, 1'b0, 0);

    // R10: interrupt enable one edge after the request
    @(negedge clk);
    irq_i = 1'b1;
    #1 chk("R10", "irq not yet seen", {31'b0, inta_oe}, 32'd0);
    @(negedge clk);
    chk("R10", "irq pulls line", {31'b0, inta_oe}, 32'd1);
    irq_i = 1'b0;
    @(negedge clk);
    chk("R10", "irq released", {31'b0, inta_oe}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule